// File: doc/BRIEF.md
# PWM Static Fault Masking Stage

This block conditions the raw output of several redundant digital PWM controllers before they reach later voting stages. Each lane compares its PWM stream with a copy of the same stream delayed by the fixed maximum duty limit. A pulse bit is passed only while the live input is high and the delayed copy is low. A healthy pulse is therefore passed whole, and a pulse that runs past the duty limit is cut off at that limit.

When a full PWM period ends with no such difference, the input was either stuck low or stuck high. For the next period the lane then emits a minimal substitute pulse, one clock long and aligned to the period-start strobe, so the stream keeps its switching frequency. The substitute stays in place until a period shows a difference again, which covers faults that last one period, several periods or for good. A per-lane flag reports, for the whole of the following period, any period that was substituted or had bits cut off.

The period is 256 clocks, which matches an 8-bit digital PWM. The duty limit is 48 percent of that period, rounded to the nearest count, which gives 123 clocks. All lanes share one period-start strobe and run independently of each other.

Top module: `pwm_static_screen`

## Requirements
- R1: In a period that is not substituted, an input pulse starting at the period strobe and at most 123 clocks long appears on `pwm_clean` unchanged: the same length, the same start, and exactly one clock later than the input.
- R2: In a period that is not substituted, `pwm_clean` is the input ANDed with the inverse of the input delayed by 123 clocks. A pulse of 124 to 133 clocks that follows a healthy period is therefore cut to 123 clocks.
- R3: If a whole period, from one strobe up to the next, shows no clock where the input is high and the delayed copy is low, the following period is substituted. In a substituted period `pwm_clean` is high for exactly one clock, one clock after the strobe, whatever the input does.
- R4: Substitution continues for every period that follows a period with no difference. Once a period shows a difference, the period after it is passed normally again. This applies both when the input is stuck low and when it is stuck high.
- R5: `stage_fault` is high for the whole of the period that follows a period that was substituted or in which an input bit was dropped because the delayed copy was high. It is low for the whole of the period that follows any other period. It changes only one clock after a strobe.
- R6: Reset (active low, asynchronous) forces `pwm_clean` and `stage_fault` low, clears the delay line, and treats the period before the first strobe as healthy, so the first period after reset is not substituted.
- R7: Each lane depends only on its own input bit. A fault on one lane does not change the output or the flag of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_tick | input | 1 | One-clock strobe on the first count of each PWM period |
| pwm_raw | input | LANES | Raw PWM bit from each redundant controller |
| pwm_clean | output | LANES | Conditioned PWM bit for each lane, registered |
| stage_fault | output | LANES | Per-lane flag for substitution or truncation in the previous period |

## Verification
On every clock the assertions check the following. A clean bit always traces back to a high input or to the strobe. No bit outside the strobe clock passes while the delayed copy is high. A substituted period stays silent apart from its one strobe clock. The flag moves only at a strobe, and it rises after any substituted period. The exact pulse lengths need whole periods of stimulus, so only the bench scenarios can show them: 123 clocks kept from an over-long pulse, a lone substitute clock, and the two-period lag of a stuck-high lane. The same holds for recovery after a transient fault and for the independence of neighbouring lanes.

// File: rtl/pwm_screen_pkg.sv
package pwm_screen_pkg;

    // Per-lane registered state of the screening decision
    typedef struct packed {
        logic seen;     // a live-high/delayed-low clock seen in this period
        logic subst;    // this period is replaced by the minimal pulse
        logic dropped;  // an input bit was blocked by the delayed copy
        logic flag;     // report for the previous period
        logic out;      // conditioned PWM bit
    } lane_state_t;

    localparam lane_state_t LANE_RST = '{seen: 1'b1, subst: 1'b0, dropped: 1'b0,
                                         flag: 1'b0, out: 1'b0};

endpackage

// File: rtl/pwm_delay_line.sv
module pwm_delay_line #(
    parameter int DEPTH = 123
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] sh_d, sh_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[DEPTH-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[DEPTH-1];
endmodule

// File: rtl/pwm_screen_lane.sv
module pwm_screen_lane
    import pwm_screen_pkg::*;
#(
    parameter int DUTY_MAX = 123
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic clean,
    output logic fault
);
    logic        dly;
    logic        diff, overlap, subst_now;
    lane_state_t st_d, st_q;

    pwm_delay_line #(.DEPTH(DUTY_MAX)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (dly)
    );

    always_comb begin
        st_d      = st_q;
        diff      = raw & ~dly;
        overlap   = raw & dly;
        subst_now = tick ? ~st_q.seen : st_q.subst;
        if (tick) begin
            st_d.seen    = diff;
            st_d.flag    = st_q.subst | st_q.dropped;
            st_d.dropped = ~subst_now & overlap;
        end else begin
            st_d.seen    = st_q.seen | diff;
            st_d.dropped = st_q.dropped | (~subst_now & overlap);
        end
        st_d.subst = subst_now;
        st_d.out   = subst_now ? tick : diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_RST;
        else        st_q <= st_d;
    end

    assign clean = st_q.out;
    assign fault = st_q.flag;

    // R1: every clean bit comes from a high input or from the strobe
    p_clean_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out |-> ($past(raw) || $past(tick)));

    // R2: outside the strobe clock, nothing passes while the delayed copy is high
    p_delay_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out && !$past(tick)) |-> !$past(dly));

    // R3: a substituted period is silent apart from the strobe clock
    p_subst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.subst && !tick) |=> !st_q.out);

    // R5: the flag changes only after a strobe
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.flag));

    // R5: a substituted period is always reported
    p_flag_after_subst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.subst) |=> st_q.flag);
endmodule

// File: rtl/pwm_static_screen.sv
module pwm_static_screen #(
    parameter int PERIOD   = 256,
    parameter int DUTY_PCT = 48,
    parameter int LANES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_tick,
    input  logic [LANES-1:0] pwm_raw,
    output logic [LANES-1:0] pwm_clean,
    output logic [LANES-1:0] stage_fault
);
    // duty limit in counts, rounded to nearest
    localparam int DUTY_MAX = (PERIOD * DUTY_PCT + 50) / 100;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            pwm_screen_lane #(.DUTY_MAX(DUTY_MAX)) u_lane (
                .clk  (clk),
                .rst_n(rst_n),
                .tick (period_tick),
                .raw  (pwm_raw[g]),
                .clean(pwm_clean[g]),
                .fault(stage_fault[g])
            );
        end
    endgenerate
endmodule

// File: tb/pwm_static_screen_tb.sv
module pwm_static_screen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_tick = 1'b0;
    logic [1:0] pwm_raw = '0;
    logic [1:0] pwm_clean;
    logic [1:0] stage_fault;

    int checks = 0;
    int errors = 0;
    int hi[2];
    int first[2];
    logic flg[2];

    pwm_static_screen #(.PERIOD(PER), .DUTY_PCT(48), .LANES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_tick(period_tick),
        .pwm_raw    (pwm_raw),
        .pwm_clean  (pwm_clean),
        .stage_fault(stage_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Drive one period: lane l is high for counts 0..h[l]-1 (0 = stuck low, 256 = stuck high)
    task automatic run_period(input int h0, input int h1);
        for (int l = 0; l < 2; l++) begin hi[l] = 0; first[l] = -1; flg[l] = 1'b0; end
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            period_tick = (c == 0);
            pwm_raw[0]  = (c < h0);
            pwm_raw[1]  = (c < h1);
            @(posedge clk);
            #1;
            for (int l = 0; l < 2; l++) begin
                if (pwm_clean[l]) begin
                    hi[l]++;
                    if (first[l] < 0) first[l] = c;
                end
                if (c == 8) flg[l] = stage_fault[l];
            end
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        period_tick = 1'b0;
        pwm_raw = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R6", "clean during reset", int'(pwm_clean), 0);
        check("R6", "flag during reset", int'(stage_fault), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R6", "clean after reset", int'(pwm_clean), 0);
    endtask

    task automatic t_healthy();
        run_period(77, 77);
        check("R6", "first period lane0 not substituted", hi[0], 77);
        check("R1", "lane0 start", first[0], 0);
        run_period(77, 77);
        check("R1", "lane1 length", hi[1], 77);
        check("R5", "lane0 flag after healthy", int'(flg[0]), 0);
        run_period(123, 123);
        check("R1", "lane0 length at limit", hi[0], 123);
        check("R1", "lane1 length at limit", hi[1], 123);
        check("R5", "lane1 flag", int'(flg[1]), 0);
    endtask

    task automatic t_overlong();
        run_period(130, 40);
        check("R2", "lane0 cut to limit", hi[0], 123);
        check("R2", "lane0 start", first[0], 0);
        check("R7", "lane1 untouched", hi[1], 40);
        run_period(77, 40);
        check("R2", "lane0 next period whole", hi[0], 77);
        check("R5", "lane0 flag after truncation", int'(flg[0]), 1);
        check("R7", "lane1 flag quiet", int'(flg[1]), 0);
        run_period(77, 40);
        check("R5", "lane0 flag cleared", int'(flg[0]), 0);
    endtask

    task automatic t_stuck_low();
        int exp_hi[5]  = '{0, 1, 1, 1, 77};
        int exp_flg[5] = '{0, 0, 1, 1, 1};
        for (int p = 0; p < 5; p++) begin
            run_period(77, (p < 3) ? 0 : 77);
            check((p == 0) ? "R3" : "R4", $sformatf("lane1 stuck-low period %0d length", p), hi[1], exp_hi[p]);
            check("R5", $sformatf("lane1 stuck-low period %0d flag", p), int'(flg[1]), exp_flg[p]);
            check("R7", $sformatf("lane0 during lane1 fault %0d", p), hi[0], 77);
            if (exp_hi[p] == 1) check("R3", "substitute at strobe", first[1], 0);
        end
        run_period(77, 77);
        check("R5", "lane1 flag after recovery", int'(flg[1]), 0);
    endtask

    task automatic t_stuck_high();
        int h[6]       = '{256, 256, 77, 77, 77, 77};
        int exp_hi[6]  = '{123, 0, 1, 1, 77, 77};
        int exp_flg[6] = '{0, 1, 1, 1, 1, 0};
        for (int p = 0; p < 6; p++) begin
            run_period(h[p], 50);
            check((p < 2) ? "R2" : "R4", $sformatf("lane0 stuck-high period %0d length", p), hi[0], exp_hi[p]);
            check("R5", $sformatf("lane0 stuck-high period %0d flag", p), int'(flg[0]), exp_flg[p]);
            check("R7", $sformatf("lane1 during lane0 fault %0d", p), hi[1], 50);
            if (exp_hi[p] == 1) check("R3", "substitute at strobe", first[0], 0);
        end
    endtask

    task automatic t_reset_mid();
        run_period(77, 0);
        run_period(77, 0);
        check("R3", "lane1 substituted before reset", hi[1], 1);
        apply_reset();
        run_period(77, 77);
        check("R6", "lane1 passes after reset", hi[1], 77);
        check("R6", "lane1 flag after reset", int'(flg[1]), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        apply_reset();
        t_healthy();
        t_overlong();
        t_stuck_low();
        t_stuck_high();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule